// File: doc/BRIEF.md
# Nonvolatile Store/Recall Controller

This block sits behind a serial command front end and manages a 16-word by 16-bit working RAM that is mirrored, word for word, by a shadow nonvolatile array. The front end delivers single-cycle command strobes: enable writes, disable writes, store, recall, and RAM write. Two active-low hardware pins can also ask for a store or a recall. The controller owns two safety latches. One is a write-enable latch. The other is a previous-recall latch, which shows that the RAM has been loaded from the shadow array on purpose. The controller grants a store only when both latches are set.

Stores (RAM to shadow) and recalls (shadow to RAM) are timed operations. Their lengths are given as clock-cycle parameters, and the block is busy for the whole length of each one. All words move together on the last cycle of the operation. When reset is released, the block runs a recall of its own. This recall refills the RAM but leaves the previous-recall latch clear, so a store cannot follow a reset until someone asks for a recall on purpose. The RAM can be read at any time except during a store. The shadow array keeps its contents across reset.

Top module: `nv_shadow_ctrl`

## Requirements
- R1: A store begins only when three things hold together: a store request is present (a store strobe or a detected falling edge on the store pin), the write-enable latch is set, and the previous-recall latch is set. A request that does not meet these conditions is dropped and busy stays low.
- R2: The write-enable strobe sets the write-enable latch and the write-disable strobe clears it. If both arrive in the same cycle, the clear wins. Reset clears the latch, and the latch also clears when a store completes.
- R3: `wrPermit` is high only while the write-enable latch is set and the block is idle. A RAM write request is applied only while `wrPermit` is high, and any other write request leaves the RAM unchanged.
- R4: An accepted recall sets the previous-recall latch, whether it came from the recall strobe or from the recall pin. Reset clears this latch.
- R5: While reset is held and for RECALL_CYCLES rising edges after its release, busy is high and an automatic recall copies every shadow word into RAM. This recall does not set the previous-recall latch. Commands that arrive during it are ignored.
- R6: While a store runs, every strobe and pin request is dropped, including write requests and latch commands. During that time `rdData` reads as zero.
- R7: A store is accepted on a clock edge. Busy then stays high for STORE_CYCLES edges, and at the end all RAM words are copied into the shadow array. A recall behaves the same way over RECALL_CYCLES edges and copies all shadow words into RAM. When no store is running, `rdData` gives the RAM word at `rdAddr` with no clock delay.
- R8: Each pin passes through a two-stage synchroniser and a falling-edge detector. A pin that goes low between two edges starts its operation on the third rising edge after that. A pin that stays low starts only one operation.
- R9: If a store and a recall are requested in the same cycle, the recall runs and the store is dropped. A request that arrives while busy is dropped and is not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; its release starts the automatic recall |
| cmdSetEn | input | 1 | Strobe that sets the write-enable latch |
| cmdClrEn | input | 1 | Strobe that clears the write-enable latch |
| cmdStore | input | 1 | Strobe that requests a store |
| cmdRecall | input | 1 | Strobe that requests a recall |
| wrReq | input | 1 | RAM write request |
| wrAddr | input | 4 | RAM write word address |
| wrData | input | 16 | RAM write data |
| rdAddr | input | 4 | RAM read word address |
| rdData | output | 16 | RAM read data; zero while a store runs |
| storePinN | input | 1 | Asynchronous active-low store request pin |
| recallPinN | input | 1 | Asynchronous active-low recall request pin |
| busy | output | 1 | High for the whole of every store and recall |
| wrPermit | output | 1 | RAM writes are currently permitted |

## Verification
A strobe driven just after one clock edge is sampled on the next edge, so busy and `wrPermit` are checked one clock later. A pin request takes three edges before busy rises, and the bench checks busy low after two edges and high after the third. Each operation's length is measured by counting edges from the command until busy falls, and the count must equal the cycle parameter plus the edge that accepted the command. `rdData` is combinational, so the bench changes `rdAddr`, waits one time step and compares the data, with every sample taken away from a clock edge.

// File: rtl/nvx_pkg.sv
package nvx_pkg;

  typedef enum logic [1:0] {
    XF_IDLE   = 2'd0,
    XF_STORE  = 2'd1,
    XF_RECALL = 2'd2
  } xferState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic ramWrite;
    logic storeCopy;
    logic recallCopy;
    logic readBlock;
  } xferStrobe_t;

endpackage

// File: rtl/nvx_pin_edge.sv
module nvx_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinN,
  output logic fall
);
  // chain[SYNC_STAGES-1] is the synchronised level, chain[SYNC_STAGES] its previous value
  logic [SYNC_STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[SYNC_STAGES-1:0], pinN};
  end

  assign fall = chain[SYNC_STAGES] & ~chain[SYNC_STAGES-1];
endmodule

// File: rtl/nvx_ctrl.sv
module nvx_ctrl
  import nvx_pkg::*;
#(
  parameter int STORE_CYCLES  = 500000,
  parameter int RECALL_CYCLES = 200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdSetEn,
  input  logic        cmdClrEn,
  input  logic        cmdStore,
  input  logic        cmdRecall,
  input  logic        wrReq,
  input  logic        storeFall,
  input  logic        recallFall,
  output xferStrobe_t strobe,
  output logic        busy,
  output logic        wrPermit,
  output logic        weLatch,
  output logic        prLatch,
  output logic        storing,
  output logic        recalling
);
  localparam int MAX_CYCLES = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
  localparam int CW = $clog2(MAX_CYCLES + 1);

  xferState_t    state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lastCnt;
  logic          idle, recallGo, storeGo, opDone;

  assign idle      = (state == XF_IDLE);
  assign storing   = (state == XF_STORE);
  assign recalling = (state == XF_RECALL);
  assign busy      = ~idle;
  assign wrPermit  = weLatch & idle;

  // recall has priority over store
  assign recallGo = idle & (cmdRecall | recallFall);
  assign storeGo  = idle & ~recallGo & (cmdStore | storeFall) & weLatch & prLatch;

  assign lastCnt = storing ? CW'(STORE_CYCLES - 1) : CW'(RECALL_CYCLES - 1);
  assign opDone  = ~idle & (cnt == lastCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= XF_RECALL;   // automatic recall after reset
      cnt     <= '0;
      weLatch <= 1'b0;
      prLatch <= 1'b0;
    end else if (idle) begin
      if (cmdClrEn)      weLatch <= 1'b0;
      else if (cmdSetEn) weLatch <= 1'b1;
      if (recallGo) begin
        state   <= XF_RECALL;
        cnt     <= '0;
        prLatch <= 1'b1;
      end else if (storeGo) begin
        state <= XF_STORE;
        cnt   <= '0;
      end
    end else if (opDone) begin
      if (storing) weLatch <= 1'b0;
      state <= XF_IDLE;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign strobe.ramWrite   = wrReq & wrPermit;
  assign strobe.storeCopy  = opDone & storing;
  assign strobe.recallCopy = opDone & recalling;
  assign strobe.readBlock  = storing;
endmodule

// File: rtl/nvx_datapath.sv
module nvx_datapath
  import nvx_pkg::*;
#(
  parameter int WORDS = 16,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(WORDS)
) (
  input  logic             clk,
  input  xferStrobe_t      strobe,
  input  logic [AW-1:0]    wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic [AW-1:0]    rdAddr,
  output logic [WIDTH-1:0] rdData
);
  logic [WIDTH-1:0] ramWord [WORDS];
  logic [WIDTH-1:0] nvWord  [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (strobe.recallCopy)
        ramWord[i] <= nvWord[i];
      else if (strobe.ramWrite && (wrAddr == AW'(i)))
        ramWord[i] <= wrData;
    end

    always_ff @(posedge clk) begin
      if (strobe.storeCopy) nvWord[i] <= ramWord[i];
    end
  end

  assign rdData = strobe.readBlock ? '0 : ramWord[rdAddr];
endmodule

// File: rtl/nv_shadow_ctrl.sv
module nv_shadow_ctrl
  import nvx_pkg::*;
#(
  parameter int WORDS         = 16,
  parameter int WIDTH         = 16,
  parameter int STORE_CYCLES  = 500000,
  parameter int RECALL_CYCLES = 200,
  localparam int AW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdSetEn,
  input  logic             cmdClrEn,
  input  logic             cmdStore,
  input  logic             cmdRecall,
  input  logic             wrReq,
  input  logic [AW-1:0]    wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic [AW-1:0]    rdAddr,
  output logic [WIDTH-1:0] rdData,
  input  logic             storePinN,
  input  logic             recallPinN,
  output logic             busy,
  output logic             wrPermit
);
  xferStrobe_t strobe;
  logic storeFall, recallFall;
  logic weLatch, prLatch, storing, recalling;

  nvx_pin_edge #(.SYNC_STAGES(2)) u_storePin (
    .clk(clk), .rstN(rstN), .pinN(storePinN), .fall(storeFall)
  );

  nvx_pin_edge #(.SYNC_STAGES(2)) u_recallPin (
    .clk(clk), .rstN(rstN), .pinN(recallPinN), .fall(recallFall)
  );

  nvx_ctrl #(
    .STORE_CYCLES(STORE_CYCLES),
    .RECALL_CYCLES(RECALL_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdSetEn(cmdSetEn), .cmdClrEn(cmdClrEn),
    .cmdStore(cmdStore), .cmdRecall(cmdRecall),
    .wrReq(wrReq), .storeFall(storeFall), .recallFall(recallFall),
    .strobe(strobe), .busy(busy), .wrPermit(wrPermit),
    .weLatch(weLatch), .prLatch(prLatch),
    .storing(storing), .recalling(recalling)
  );

  nvx_datapath #(.WORDS(WORDS), .WIDTH(WIDTH)) u_dp (
    .clk(clk), .strobe(strobe),
    .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/nvx_checker.sv
module nvx_checker (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic ramWrite,
  input logic weLatch,
  input logic prLatch,
  input logic storing,
  input logic recalling
);
  logic sawIdle;

  always_ff @(posedge clk) begin
    if (!rstN)     sawIdle <= 1'b0;
    else if (!busy) sawIdle <= 1'b1;
  end

  assert_store_needs_latches_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(storing) |-> ($past(weLatch) && $past(prLatch)));

  assert_we_cleared_after_store_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(storing) |-> !weLatch);

  assert_write_needs_permit_R3: assert property (@(posedge clk) disable iff (!rstN)
    ramWrite |-> (weLatch && !busy));

  assert_pr_set_by_recall_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(prLatch) |-> recalling);

  assert_powerup_leaves_pr_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    !sawIdle |-> !prLatch);

  assert_store_freezes_latches_R6: assert property (@(posedge clk) disable iff (!rstN)
    (storing && $past(storing)) |-> ($stable(weLatch) && $stable(prLatch)));
endmodule

bind nv_shadow_ctrl nvx_checker u_nvxChecker (
  .clk(clk), .rstN(rstN), .busy(busy), .ramWrite(strobe.ramWrite),
  .weLatch(weLatch), .prLatch(prLatch),
  .storing(storing), .recalling(recalling)
);

// File: tb/nv_shadow_ctrl_bench.sv
module nv_shadow_ctrl_bench;
  localparam int SC = 40;
  localparam int RC = 6;

  localparam logic [2:0] K_SETEN = 3'd0, K_CLREN = 3'd1, K_WR = 3'd2,
                         K_RD = 3'd3, K_STORE = 3'd4, K_RECALL = 3'd5;

  typedef struct packed {
    logic [2:0]  kind;
    logic [3:0]  addr;
    logic [15:0] val;
  } vec_t;

  localparam vec_t VECS [20] = '{
    '{K_SETEN,  4'h0, 16'h0000},
    '{K_STORE,  4'h0, 16'h0000},   // no previous recall yet
    '{K_RECALL, 4'h0, 16'h0001},
    '{K_WR,     4'h1, 16'hAAAA},
    '{K_WR,     4'h7, 16'h1234},
    '{K_RD,     4'h1, 16'hAAAA},
    '{K_CLREN,  4'h0, 16'h0000},
    '{K_WR,     4'h1, 16'h5555},   // dropped
    '{K_RD,     4'h1, 16'hAAAA},
    '{K_STORE,  4'h0, 16'h0000},   // write enable clear
    '{K_SETEN,  4'h0, 16'h0000},
    '{K_STORE,  4'h0, 16'h0001},
    '{K_WR,     4'h1, 16'h0000},   // latch cleared by store
    '{K_RD,     4'h1, 16'hAAAA},
    '{K_SETEN,  4'h0, 16'h0000},
    '{K_WR,     4'h1, 16'h0F0F},
    '{K_RD,     4'h1, 16'h0F0F},
    '{K_RECALL, 4'h0, 16'h0001},
    '{K_RD,     4'h1, 16'hAAAA},
    '{K_RD,     4'h7, 16'h1234}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdSetEn = 0, cmdClrEn = 0, cmdStore = 0, cmdRecall = 0, wrReq = 0;
  logic [3:0]  wrAddr = '0, rdAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic storePinN = 1'b1, recallPinN = 1'b1;
  logic busy, wrPermit;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  nv_shadow_ctrl #(.STORE_CYCLES(SC), .RECALL_CYCLES(RC)) u_nv_shadow_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdSetEn(cmdSetEn), .cmdClrEn(cmdClrEn),
    .cmdStore(cmdStore), .cmdRecall(cmdRecall),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .storePinN(storePinN), .recallPinN(recallPinN),
    .busy(busy), .wrPermit(wrPermit)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFail++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy && n < 100000) begin
      tick();
      n++;
    end
  endtask

  task automatic readChk(input logic [3:0] a, input logic [15:0] e, input string tag);
    rdAddr = a;
    #1;
    chk(rdData == e, tag, int'(rdData), int'(e));
  endtask

  initial begin
    int n;
    // ---- reset and power-up recall (R5)
    tick(); tick(); tick();
    chk(busy == 1'b1, "R5 busy during reset", int'(busy), 1);
    chk(wrPermit == 1'b0, "R2 R3 wrPermit during reset", int'(wrPermit), 0);
    rstN = 1'b1;
    cmdSetEn = 1'b1;
    n = 0;
    tick(); n++;
    cmdSetEn = 1'b0;
    while (busy && n < 1000) begin tick(); n++; end
    chk(n == RC, "R5 power-up recall length", n, RC);
    chk(wrPermit == 1'b0, "R5 command ignored during power-up recall", int'(wrPermit), 0);

    // ---- vector table
    for (int i = 0; i < 20; i++) begin
      case (VECS[i].kind)
        K_SETEN:  begin cmdSetEn = 1'b1; tick(); cmdSetEn = 1'b0; end
        K_CLREN:  begin cmdClrEn = 1'b1; tick(); cmdClrEn = 1'b0; end
        K_WR: begin
          wrReq = 1'b1; wrAddr = VECS[i].addr; wrData = VECS[i].val;
          tick();
          wrReq = 1'b0;
        end
        K_RD: readChk(VECS[i].addr, VECS[i].val, "R3 R7 table read");
        K_STORE: begin
          cmdStore = 1'b1; tick(); cmdStore = 1'b0;
          chk(busy == VECS[i].val[0], "R1 R7 table store start", int'(busy), int'(VECS[i].val[0]));
          waitIdle(n);
        end
        default: begin
          cmdRecall = 1'b1; tick(); cmdRecall = 1'b0;
          chk(busy == VECS[i].val[0], "R4 R7 table recall start", int'(busy), int'(VECS[i].val[0]));
          waitIdle(n);
        end
      endcase
    end

    // ---- store length and blocking during store (R6, R7)
    cmdSetEn = 1'b1; tick(); cmdSetEn = 1'b0;
    cmdStore = 1'b1; n = 0; tick(); n++; cmdStore = 1'b0;
    chk(busy == 1'b1, "R7 store accepted", int'(busy), 1);
    cmdRecall = 1'b1; cmdClrEn = 1'b1; wrReq = 1'b1; wrAddr = 4'h1; wrData = 16'hFFFF;
    tick(); n++;
    cmdRecall = 1'b0; cmdClrEn = 1'b0; wrReq = 1'b0;
    readChk(4'h1, 16'h0000, "R6 read blocked during store");
    while (busy && n < 1000) begin tick(); n++; end
    chk(n == SC + 1, "R7 store length", n, SC + 1);
    tick();
    chk(busy == 1'b0, "R9 recall during store dropped", int'(busy), 0);
    chk(wrPermit == 1'b0, "R2 latch cleared at store end", int'(wrPermit), 0);
    readChk(4'h1, 16'hAAAA, "R6 write during store dropped");

    // ---- store pin: latency and single trigger (R8)
    cmdSetEn = 1'b1; tick(); cmdSetEn = 1'b0;
    storePinN = 1'b0;
    tick(); tick();
    chk(busy == 1'b0, "R8 pin store not before third edge", int'(busy), 0);
    tick();
    chk(busy == 1'b1, "R8 pin store on third edge", int'(busy), 1);
    waitIdle(n);
    chk(wrPermit == 1'b0, "R2 pin store cleared latch", int'(wrPermit), 0);
    cmdSetEn = 1'b1; tick(); cmdSetEn = 1'b0;
    repeat (10) tick();
    chk(busy == 1'b0, "R8 held pin triggers once", int'(busy), 0);
    storePinN = 1'b1;
    repeat (3) tick();

    // ---- simultaneous store and recall (R9)
    cmdStore = 1'b1; cmdRecall = 1'b1; n = 0; tick(); n++;
    cmdStore = 1'b0; cmdRecall = 1'b0;
    while (busy && n < 1000) begin tick(); n++; end
    chk(n == RC + 1, "R9 recall wins length", n, RC + 1);
    chk(wrPermit == 1'b1, "R9 store dropped, latch kept", int'(wrPermit), 1);

    // ---- set and clear together (R2)
    cmdSetEn = 1'b1; cmdClrEn = 1'b1; tick(); cmdSetEn = 1'b0; cmdClrEn = 1'b0;
    chk(wrPermit == 1'b0, "R2 clear wins over set", int'(wrPermit), 0);

    // ---- recall request while busy is dropped (R9)
    cmdRecall = 1'b1; tick(); cmdRecall = 1'b0;
    tick();
    cmdRecall = 1'b1; tick(); cmdRecall = 1'b0;
    waitIdle(n);
    tick();
    chk(busy == 1'b0, "R9 request while busy not queued", int'(busy), 0);

    // ---- second reset: shadow retained, previous-recall cleared (R4, R5)
    rstN = 1'b0; tick(); tick(); rstN = 1'b1;
    waitIdle(n);
    readChk(4'h1, 16'hAAAA, "R5 power-up recall restores word 1");
    readChk(4'h7, 16'h1234, "R5 power-up recall restores word 7");
    cmdSetEn = 1'b1; tick(); cmdSetEn = 1'b0;
    cmdStore = 1'b1; tick(); cmdStore = 1'b0;
    chk(busy == 1'b0, "R4 store refused after reset", int'(busy), 0);
    recallPinN = 1'b0;
    tick(); tick(); tick();
    chk(busy == 1'b1, "R8 recall pin on third edge", int'(busy), 1);
    waitIdle(n);
    recallPinN = 1'b1;
    cmdStore = 1'b1; tick(); cmdStore = 1'b0;
    chk(busy == 1'b1, "R4 pin recall enables store", int'(busy), 1);
    waitIdle(n);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule